// File: doc/BRIEF.md
# Blanked Peak Current Limiter with On-Time Averaging

This block watches a stream of digitized current-sense samples, one per clock, while a bridge lower switch is being driven. Once a leading-edge blanking window at the start of each pulse has passed, any sample at or above a programmable threshold raises a terminate request in the same cycle. The pulse generator uses that request to cut the active pulse short. An overcurrent is not treated as a fault. The request simply follows the samples from cycle to cycle and never latches.

In parallel, the block adds up the samples it accepts during the on-time and counts them. When the pulse ends, it loads a held output with four times the mean of that pulse's accepted samples. The sum and the count are then cleared for the next pulse. The held value stays fixed until a later pulse ends with at least one accepted sample. It can feed a slow average-current limiting loop or current sharing.

Top module: `cs_peak_avg`

## Requirements
- R1: While `pulse_on` is high and the blanking window has expired, `trip` is 1 in the same cycle that `sense >= limit`. Equality counts as over the limit.
- R2: The first `BLANK_CYC` cycles with `pulse_on` high after each low-to-high change are blanked. Blanked samples never raise `trip` and are not added to the average.
- R3: `trip` is 0 whenever `pulse_on` is low or `sense < limit`. It does not latch: it drops in the first unblanked cycle whose sample is below the limit.
- R4: Only unblanked samples taken while `pulse_on` is high contribute to the average.
- R5: At the first rising clock edge where `pulse_on` is sampled low after a pulse with N ≥ 1 accepted samples, `avg_out` becomes floor(4·sum/N).
- R6: `avg_out` does not change at any clock edge where `pulse_on` is sampled high.
- R7: At the end of each pulse, the sum and the count are cleared, so each pulse's average depends only on its own samples.
- R8: If a pulse ends with no accepted sample (its length is at most `BLANK_CYC` cycles), `avg_out` keeps its previous value.
- R9: `avg_out` saturates at 2^`OUT_W`−1. The count holds at most 2^`CNT_W`−1 samples, and later samples in the same pulse are not accumulated.
- R10: After reset, `avg_out` is 0 and `trip` is 0 while `pulse_on` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_on | input | 1 | High while the lower switch pulse is active |
| sense | input | SAMPLE_W | Current-sense sample, unsigned |
| limit | input | SAMPLE_W | Peak threshold, unsigned |
| trip | output | 1 | Terminate request for the active pulse |
| avg_out | output | OUT_W | Held value of four times the per-pulse mean |

## Verification
The bench builds the block with an 8-bit sample width, a blanking window of 3 cycles, a 4-bit sample count and a 9-bit output. With a 9-bit output, four times a large mean goes past the output range, so the saturating variant is the one that gets built and exercised. With a 4-bit count, a 25-cycle pulse fills the count at 15 samples and shows that later samples are dropped. With a 3-cycle blanking window, the bench can drive pulses shorter than, equal to and just longer than the window, which covers the keep-previous-value case of R8.

// File: rtl/cspa_pkg.sv
package cspa_pkg;
   // Position of the current cycle inside a lower-switch pulse
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,   // pulse inactive
      PH_BLANK = 2'd1,   // inside leading-edge blanking
      PH_LIVE  = 2'd2    // unblanked on-time
   } pulse_ph_e;
endpackage

// File: rtl/cspa_blank_timer.sv
module cspa_blank_timer
   import cspa_pkg::*;
#(
   parameter int BLANK_CYC = 7
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pulse_on,
   output pulse_ph_e ph
);
   generate
      if (BLANK_CYC == 0) begin : g_noblank
         assign ph = pulse_on ? PH_LIVE : PH_IDLE;
      end else begin : g_blank
         localparam int BW = $clog2(BLANK_CYC + 1);
         localparam logic [BW-1:0] BEND = BW'(BLANK_CYC);
         logic [BW-1:0] bcnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              bcnt <= '0;
            else if (!pulse_on)      bcnt <= '0;
            else if (bcnt != BEND)   bcnt <= bcnt + 1'b1;
         end

         assign ph = !pulse_on ? PH_IDLE :
                     (bcnt == BEND) ? PH_LIVE : PH_BLANK;

         // R2: first active cycle of every pulse is blanked
         assert_blank_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulse_on) |-> (ph == PH_BLANK));
      end
   endgenerate
endmodule

// File: rtl/cspa_peak_cmp.sv
module cspa_peak_cmp
   import cspa_pkg::*;
#(
   parameter int SAMPLE_W = 10
) (
   input  pulse_ph_e           ph,
   input  logic [SAMPLE_W-1:0] sense,
   input  logic [SAMPLE_W-1:0] limit,
   output logic                trip
);
   always_comb trip = (ph == PH_LIVE) && (sense >= limit);
endmodule

// File: rtl/cspa_pulse_avg.sv
module cspa_pulse_avg
   import cspa_pkg::*;
#(
   parameter int SAMPLE_W = 10,
   parameter int CNT_W    = 8,
   parameter int OUT_W    = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  pulse_ph_e           ph,
   input  logic [SAMPLE_W-1:0] sense,
   output logic [OUT_W-1:0]    avg_q
);
   localparam int AW = SAMPLE_W + CNT_W;
   localparam int WW = AW + 2;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [AW-1:0]    acc;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] denom;
   logic [WW-1:0]    mean4;
   logic [OUT_W-1:0] scaled;

   always_comb begin
      denom = (cnt == '0) ? CNT_W'(1) : cnt;
      mean4 = (WW'(acc) << 2) / WW'(denom);
   end

   generate
      if (OUT_W >= WW) begin : g_wide
         assign scaled = OUT_W'(mean4);
      end else if (OUT_W >= SAMPLE_W + 2) begin : g_fit
         assign scaled = mean4[OUT_W-1:0];
      end else begin : g_clamp
         localparam logic [WW-1:0] OUT_MAX = WW'({OUT_W{1'b1}});
         assign scaled = (mean4 > OUT_MAX) ? {OUT_W{1'b1}} : mean4[OUT_W-1:0];

         // R9: held output never exceeds the output range after clamping
         assert_sat_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ph == PH_IDLE && cnt != '0 && mean4 > OUT_MAX) |=> (avg_q == {OUT_W{1'b1}}));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         cnt   <= '0;
         avg_q <= '0;
      end else begin
         case (ph)
            PH_LIVE: begin
               if (cnt != CNT_MAX) begin
                  acc <= acc + AW'(sense);
                  cnt <= cnt + 1'b1;
               end
            end
            PH_IDLE: begin
               if (cnt != '0) avg_q <= scaled;
               acc <= '0;
               cnt <= '0;
            end
            default: ;
         endcase
      end
   end

   // R6: held value is stable while the pulse is active
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE) |=> $stable(avg_q));
   // R7: sense path cleared once the pulse has ended
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE) |=> (cnt == '0 && acc == '0));
   // R8: a pulse without accepted samples leaves the output untouched
   assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE && cnt == '0) |=> $stable(avg_q));
endmodule

// File: rtl/cs_peak_avg.sv
module cs_peak_avg
   import cspa_pkg::*;
#(
   parameter int SAMPLE_W  = 10,
   parameter int BLANK_CYC = 7,
   parameter int CNT_W     = 8,
   parameter int OUT_W     = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pulse_on,
   input  logic [SAMPLE_W-1:0] sense,
   input  logic [SAMPLE_W-1:0] limit,
   output logic                trip,
   output logic [OUT_W-1:0]    avg_out
);
   generate
      if (SAMPLE_W < 2)  begin : g_bad_sw  $error("SAMPLE_W must be at least 2"); end
      if (BLANK_CYC < 0) begin : g_bad_bc  $error("BLANK_CYC must not be negative"); end
      if (CNT_W < 1)     begin : g_bad_cw  $error("CNT_W must be at least 1"); end
      if (OUT_W < 2 || OUT_W > 30) begin : g_bad_ow $error("OUT_W out of range"); end
   endgenerate

   pulse_ph_e ph;

   cspa_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk(clk), .rst_n(rst_n), .pulse_on(pulse_on), .ph(ph));

   cspa_peak_cmp #(.SAMPLE_W(SAMPLE_W)) u_peak (
      .ph(ph), .sense(sense), .limit(limit), .trip(trip));

   cspa_pulse_avg #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .OUT_W(OUT_W)) u_avg (
      .clk(clk), .rst_n(rst_n), .ph(ph), .sense(sense), .avg_q(avg_out));

   // R3: no request outside the pulse
   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_on |-> !trip);
   // R1: a request always reflects an over-limit sample
   assert_trip_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      trip |-> (sense >= limit));
   // R6: output only moves at edges where the pulse is seen low
   assert_port_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_on |=> $stable(avg_out));
endmodule

// File: tb/cs_peak_avg_tb.sv
module cs_peak_avg_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 8;
   localparam int BC = 3;
   localparam int CW = 4;
   localparam int OW = 9;
   localparam int CAP = (1 << CW) - 1;
   localparam int OMAX = (1 << OW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pulse_on = 1'b0;
   logic [SW-1:0] sense = '0;
   logic [SW-1:0] limit = '0;
   logic          trip;
   logic [OW-1:0] avg_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   cs_peak_avg #(.SAMPLE_W(SW), .BLANK_CYC(BC), .CNT_W(CW), .OUT_W(OW)) u_dut (
      .clk(clk), .rst_n(rst_n), .pulse_on(pulse_on), .sense(sense), .limit(limit),
      .trip(trip), .avg_out(avg_out));

   int    vectors = 0;
   int    miscompares = 0;
   int    idx = 0;
   int    q[$];
   int    exp_avg = 0;
   string tag = "R10";
   bit    done = 0;

   task automatic step(input bit p, input int s);
      bit exp_trip;
      pulse_on = p;
      sense = SW'(s);
      #1;
      exp_trip = p && (idx >= BC) && (s >= int'(limit));
      vectors++;
      if (trip !== exp_trip) begin
         miscompares++;
         $display("FAIL %s trip got %0b expected %0b", tag, trip, exp_trip);
      end
      if (int'(avg_out) != exp_avg) begin
         miscompares++;
         $display("FAIL %s avg_out got %0d expected %0d", tag, avg_out, exp_avg);
      end
      @(posedge clk);
      if (p) begin
         if (idx >= BC && q.size() < CAP) q.push_back(s);
         idx++;
      end else begin
         if (q.size() > 0) begin
            int sum = 0;
            foreach (q[i]) sum += q[i];
            exp_avg = (4 * sum) / q.size();
            if (exp_avg > OMAX) exp_avg = OMAX;
         end
         q.delete();
         idx = 0;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      tag = "R10";
      for (int i = 0; i < 3; i++) step(0, 0);
      // R4/R5: ramp below limit, blanked samples excluded from mean
      tag = "R5";
      limit = 8'd200;
      for (int i = 0; i < 10; i++) step(1, 10 * (i + 1));
      step(0, 0); step(0, 0);
      tag = "R4";
      for (int i = 0; i < 6; i++) step(1, (i < BC) ? 190 : 7);
      step(0, 0);
      // R2: large samples inside blanking; R1 equal and above; R3 release
      tag = "R2";
      limit = 8'd50;
      step(1, 250); step(1, 250); step(1, 250);
      tag = "R1";
      step(1, 40); step(1, 50); step(1, 60);
      tag = "R3";
      step(1, 30); step(1, 49); step(0, 255); step(0, 0);
      // R8: pulses not longer than the blanking window
      tag = "R8";
      step(1, 90); step(1, 90); step(0, 0); step(0, 0);
      step(1, 90); step(1, 90); step(1, 90); step(0, 0); step(0, 0);
      // R9: output saturation
      tag = "R9";
      limit = 8'd255;
      for (int i = 0; i < 8; i++) step(1, 200);
      step(0, 0); step(0, 0);
      // R9: count capacity reached, later samples dropped
      for (int i = 0; i < 25; i++) step(1, (i < 18) ? 4 : 250);
      step(0, 0); step(0, 0);
      // R7: back-to-back pulses, independent averages; R6 held during pulse
      tag = "R7";
      for (int i = 0; i < 6; i++) step(1, 20);
      step(0, 0);
      tag = "R6";
      for (int i = 0; i < 6; i++) step(1, 5);
      step(0, 0); step(0, 0);
      // R1: mixed pattern
      tag = "R1";
      limit = 8'd180;
      for (int k = 0; k < 300; k++) step(((k / 7) % 3) != 0, (k * 37) % 256);
      step(0, 0); step(0, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired got running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule